// File: doc/BRIEF.md
# Dual-Rate Settable Countdown Timer

This block holds a four-digit decimal value for a row of seven-segment displays and counts it down once per second. A pause input freezes the count. While a set button is held, the value moves at four steps per second instead, up or down as a direction button selects, so that a large starting value can be loaded quickly.

All registers share one system clock. Both rates are single-cycle enable strobes from one free-running prescaler. Neither rate is a separate clock, so moving between run and set mode never produces a short clock period or a burst of extra counts. The pause, set and direction inputs each pass through a two-flop synchroniser before use. Segment decoding and digit multiplexing are left to the display driver downstream.

Top module: `dual_rate_countdown`

## Requirements
- R1: A synchronous reset clears all digits to 0000, raises `zero_o` and clears the prescaler. The timer then does not count down until a set press has been made and released.
- R2: In run mode the value drops by one on every slow tick, which comes every FAST_DIV*SLOW_MULT clock cycles. A borrow ripples across digits, so 1000 becomes 0999. Digit i sits at `bcd_o[4i+3:4i]`, and digit 0 is the least significant.
- R3: While the synchronised pause is high and set is low, the value does not change.
- R4: While set is held, the value steps once every FAST_DIV cycles. With direction 0 it counts up and 9999 wraps to 0000. With direction 1 it counts down and 0000 wraps to 9999.
- R5: When set is first seen, the prescaler restarts and no step happens on that edge. The first fast step lands exactly FAST_DIV cycles after the restart, which is 3+FAST_DIV clock edges after `set_i` rises.
- R6: In run mode the count stops at 0000 and does not wrap. `zero_o` is high exactly when all digits are zero.
- R7: Set takes priority over pause. With both held, the value keeps stepping at the fast rate. Each input takes effect two edges after it changes.
- R8: The value changes by at most one count per clock cycle, only on a prescaler strobe, and every digit always stays within 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pause_i | input | 1 | Pause request, asynchronous level |
| set_i | input | 1 | Set button, asynchronous level |
| dir_i | input | 1 | Set direction: 0 up, 1 down |
| bcd_o | output | DIGITS*4 | Packed BCD digits, digit 0 in the low nibble |
| zero_o | output | 1 | High when the value is 0000 |

## Verification
A wrong digit register, a lost borrow or a lost carry shows on `bcd_o` at the next strobe edge. It is caught in the same cycle, because the bench keeps an integer model of the value and compares it against the outputs after every edge. A prescaler or restart fault moves the first fast step, or the spacing between slow steps, by at least one cycle. The bench measures that spacing exactly. A synchroniser or priority fault moves the edge at which stepping starts or stops, and the model shows that as a mismatch within a few cycles.

// File: rtl/drc_pkg.sv
package drc_pkg;

   localparam int BCD_W = 4;

   typedef logic [BCD_W-1:0] bcd_t;

   // next value of one decimal digit for a single step
   function automatic bcd_t bcd_next(bcd_t d, logic up);
      if (up) return (d == 4'd9) ? 4'd0 : bcd_t'(d + 4'd1);
      else    return (d == 4'd0) ? 4'd9 : bcd_t'(d - 4'd1);
   endfunction

   // digit passes the step on to the next higher digit
   function automatic logic bcd_rolls(bcd_t d, logic up);
      return up ? (d == 4'd9) : (d == 4'd0);
   endfunction

endpackage

// File: rtl/drc_sync.sv
module drc_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stage_q[0] <= '0;
      else     stage_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stage_q[s] <= '0;
         else     stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/drc_prescaler.sv
module drc_prescaler #(
   parameter int FAST_DIV  = 4,
   parameter int SLOW_MULT = 4
)(
   input  logic clk,
   input  logic rst,
   input  logic restart_i,
   output logic fast_o,
   output logic slow_o
);

   localparam int CW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;

   logic [CW-1:0] cnt_q;

   assign fast_o = (cnt_q == CW'(FAST_DIV - 1));

   always_ff @(posedge clk) begin
      if (rst || restart_i) cnt_q <= '0;
      else if (fast_o)      cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
   end

   if (SLOW_MULT == 1) begin : g_same_rate
      assign slow_o = fast_o;
   end else begin : g_phase
      localparam int PW = $clog2(SLOW_MULT);
      logic [PW-1:0] ph_q;
      logic          ph_last;

      assign ph_last = (ph_q == PW'(SLOW_MULT - 1));
      assign slow_o  = fast_o && ph_last;

      always_ff @(posedge clk) begin
         if (rst || restart_i) ph_q <= '0;
         else if (fast_o)      ph_q <= ph_last ? '0 : ph_q + 1'b1;
      end
   end

endmodule

// File: rtl/drc_bcd_cell.sv
module drc_bcd_cell
   import drc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic step_i,
   input  logic up_i,
   output bcd_t digit_o
);

   bcd_t digit_q;

   always_ff @(posedge clk) begin
      if (rst)         digit_q <= '0;
      else if (step_i) digit_q <= bcd_next(digit_q, up_i);
   end

   assign digit_o = digit_q;

endmodule

// File: rtl/dual_rate_countdown.sv
module dual_rate_countdown
   import drc_pkg::*;
#(
   parameter int DIGITS      = 4,
   parameter int FAST_DIV    = 12_500_000,
   parameter int SLOW_MULT   = 4,
   parameter int SYNC_STAGES = 2
)(
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    pause_i,
   input  logic                    set_i,
   input  logic                    dir_i,
   output logic [DIGITS*BCD_W-1:0] bcd_o,
   output logic                    zero_o
);

   localparam int VW = DIGITS * BCD_W;

   if (DIGITS < 1) begin : g_bad_digits
      $error("DIGITS must be at least 1");
   end
   if (FAST_DIV < 2) begin : g_bad_div
      $error("FAST_DIV must be at least 2");
   end
   if (SLOW_MULT < 1) begin : g_bad_mult
      $error("SLOW_MULT must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // synchronised controls
   logic [2:0] sync_q;
   logic       set_s, pause_s, dir_s;

   drc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({dir_i, pause_i, set_i}),
      .q   (sync_q)
   );

   assign set_s   = sync_q[0];
   assign pause_s = sync_q[1];
   assign dir_s   = sync_q[2];

   // set edge tracking and arming after reset
   logic set_prev_q, armed_q;
   logic set_rise, set_fall, set_mode;

   assign set_rise = set_s & ~set_prev_q;
   assign set_fall = ~set_s & set_prev_q;
   assign set_mode = set_s & set_prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         set_prev_q <= 1'b0;
         armed_q    <= 1'b0;
      end else begin
         set_prev_q <= set_s;
         if (set_fall) armed_q <= 1'b1;
      end
   end

   // rate strobes
   logic fast_stb, slow_stb;

   drc_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_MULT(SLOW_MULT)) u_pre (
      .clk       (clk),
      .rst       (rst),
      .restart_i (set_rise),
      .fast_o    (fast_stb),
      .slow_o    (slow_stb)
   );

   // step decision
   logic run_step, set_step, step, count_up;

   assign zero_o   = ~|bcd_o;
   assign run_step = ~set_s & armed_q & ~pause_s & slow_stb & ~zero_o;
   assign set_step = set_mode & fast_stb;
   assign step     = set_step | run_step;
   assign count_up = set_mode & ~dir_s;

   // digit chain with carry / borrow ripple
   logic [DIGITS-1:0] chain;
   assign chain[0] = step;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      drc_bcd_cell u_cell (
         .clk     (clk),
         .rst     (rst),
         .step_i  (chain[g]),
         .up_i    (count_up),
         .digit_o (bcd_o[g*BCD_W +: BCD_W])
      );
      if (g < DIGITS - 1) begin : g_link
         assign chain[g+1] = chain[g] & bcd_rolls(bcd_o[g*BCD_W +: BCD_W], count_up);
      end
   end

   logic [VW-1:0] unused_vw;
   assign unused_vw = '0;

endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
   parameter int DIGITS = 4
)(
   input logic                  clk,
   input logic                  rst,
   input logic [DIGITS*4-1:0]   bcd,
   input logic                  zero,
   input logic                  fast,
   input logic                  set_s,
   input logic                  set_mode,
   input logic                  pause_s,
   input logic                  armed
);

   function automatic logic digits_ok(logic [DIGITS*4-1:0] v);
      for (int i = 0; i < DIGITS; i++)
         if (v[i*4 +: 4] > 4'd9) return 1'b0;
      return 1'b1;
   endfunction

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (bcd == '0 && zero));

   // R1
   unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!armed && !set_s) |=> $stable(bcd));

   // R3
   pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pause_s && !set_s) |=> $stable(bcd));

   // R5
   no_step_on_detect_chk: assert property (@(posedge clk) disable iff (rst)
      (set_s && !set_mode) |=> $stable(bcd));

   // R4
   fast_single_chk: assert property (@(posedge clk) disable iff (rst)
      fast |=> !fast);

   // R6
   zero_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (zero && !set_s) |=> zero);

   // R8
   strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
      !fast |=> $stable(bcd));

   // R8
   digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      digits_ok(bcd));

endmodule

bind dual_rate_countdown drc_checker #(.DIGITS(DIGITS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bcd      (bcd_o),
   .zero     (zero_o),
   .fast     (fast_stb),
   .set_s    (set_s),
   .set_mode (set_mode),
   .pause_s  (pause_s),
   .armed    (armed_q)
);

// File: tb/dual_rate_countdown_test.sv
module dual_rate_countdown_test;

   localparam int CLK_PERIOD = 10;
   localparam int DIV  = 5;
   localparam int MULT = 4;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pause_i = 1'b0, set_i = 1'b0, dir_i = 1'b0;
   logic [15:0] bcd_o;
   logic zero_o;

   int checks = 0, errors = 0, cyc = 0;
   bit up_wrap_seen = 0, dn_wrap_seen = 0;
   int prev_val = 0;

   dual_rate_countdown #(.DIGITS(4), .FAST_DIV(DIV), .SLOW_MULT(MULT), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .pause_i(pause_i), .set_i(set_i), .dir_i(dir_i),
      .bcd_o(bcd_o), .zero_o(zero_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] to_bcd(int v);
      logic [15:0] r;
      int p = 1;
      for (int i = 0; i < 4; i++) begin
         r[i*4 +: 4] = 4'((v / p) % 10);
         p = p * 10;
      end
      return r;
   endfunction

   function automatic int dut_val();
      int v = 0, p = 1;
      for (int i = 0; i < 4; i++) begin
         v = v + int'(bcd_o[i*4 +: 4]) * p;
         p = p * 10;
      end
      return v;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_val = 0, m_cnt = 0, m_ph = 0;
   bit s1, s2, sp, p1, p2, d1, d2, armed;

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_val = 0; m_cnt = 0; m_ph = 0;
         s1 = 0; s2 = 0; sp = 0; p1 = 0; p2 = 0; d1 = 0; d2 = 0; armed = 0;
      end else begin
         bit fast, slow, rise, setm;
         int nv;
         fast = (m_cnt == DIV - 1);
         slow = fast && (m_ph == MULT - 1);
         rise = s2 && !sp;
         setm = s2 && sp;
         nv = m_val;
         if (setm && fast)
            nv = d2 ? (m_val + 9999) % 10000 : (m_val + 1) % 10000;
         else if (!s2 && armed && !p2 && slow && m_val != 0)
            nv = m_val - 1;
         if (rise) begin m_cnt = 0; m_ph = 0; end
         else if (fast) begin m_cnt = 0; m_ph = (m_ph + 1) % MULT; end
         else m_cnt++;
         if (!s2 && sp) armed = 1;
         sp = s2; s2 = s1; s1 = set_i;
         p2 = p1; p1 = pause_i;
         d2 = d1; d1 = dir_i;
         m_val = nv;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      int dv;
      dv = dut_val();
      checks++;
      if (bcd_o !== to_bcd(m_val) || zero_o !== (m_val == 0)) begin
         errors++;
         $display("FAIL R8 model mismatch actual=%0d expected=%0d zero=%0b", dv, m_val, zero_o);
      end
      if (!rst) begin
         if (prev_val == 9999 && dv == 0) up_wrap_seen = 1;
         if (prev_val == 0 && dv == 9999) dn_wrap_seen = 1;
      end
      prev_val = dv;
   end

   always @(posedge clk) begin
      if (cyc > LIMIT) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_val(int v, int maxc);
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (dut_val() == v) return;
      end
   endtask

   initial begin
      int v, n;
      repeat (3) @(negedge clk);
      check(bcd_o == 16'h0000, "R1 reset digits", dut_val(), 0);
      check(zero_o == 1'b1, "R1 reset zero flag", zero_o, 1);
      rst = 1'b0;
      repeat (60) @(negedge clk);
      check(dut_val() == 0, "R1 idle after reset", dut_val(), 0);

      // R5 first fast step timing
      set_i = 1'b1; dir_i = 1'b0;
      repeat (2 + DIV) @(negedge clk);
      check(dut_val() == 0, "R5 no early step", dut_val(), 0);
      @(negedge clk);
      check(dut_val() == 1, "R5 first step", dut_val(), 1);
      repeat (11 * DIV) @(negedge clk);
      check(dut_val() == 12, "R4 fast rate up", dut_val(), 12);

      // R4 down through zero, then back up through zero
      dir_i = 1'b1;
      wait_val(9995, 400);
      check(dut_val() == 9995, "R4 count down", dut_val(), 9995);
      dir_i = 1'b0;
      wait_val(3, 400);
      set_i = 1'b0;
      check(dn_wrap_seen, "R4 0000 to 9999", dn_wrap_seen, 1);
      check(up_wrap_seen, "R4 9999 to 0000", up_wrap_seen, 1);

      // R6 run stops at zero
      wait_val(0, 200);
      check(zero_o == 1'b1, "R6 reached zero", zero_o, 1);
      repeat (60) @(negedge clk);
      check(dut_val() == 0 && zero_o, "R6 stays at zero", dut_val(), 0);

      // R2 borrow and slow period
      set_i = 1'b1;
      wait_val(1000, 6000);
      set_i = 1'b0;
      wait_val(999, 300);
      check(bcd_o == 16'h0999, "R2 borrow 1000 to 0999", bcd_o, 16'h0999);
      n = 0;
      while (dut_val() == 999 && n < 100) begin
         @(negedge clk);
         n++;
      end
      check(n == DIV * MULT, "R2 slow tick period", n, DIV * MULT);
      check(dut_val() == 998, "R2 single decrement", dut_val(), 998);

      // R3 pause
      pause_i = 1'b1;
      repeat (3) @(negedge clk);
      v = dut_val();
      repeat (100) @(negedge clk);
      check(dut_val() == v, "R3 paused value held", dut_val(), v);

      // R7 set over pause
      set_i = 1'b1;
      repeat (40) @(negedge clk);
      check(dut_val() != v, "R7 set overrides pause", dut_val(), v + 1);
      set_i = 1'b0;
      repeat (4) @(negedge clk);
      v = dut_val();
      repeat (60) @(negedge clk);
      check(dut_val() == v, "R3 pause after set", dut_val(), v);
      pause_i = 1'b0;
      repeat (45) @(negedge clk);
      check(dut_val() < v, "R2 resumes after pause", dut_val(), v - 2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule